// File: doc/BRIEF.md
# Eight-Channel Logic Capture Buffer Controller

This block records eight digital input lines into an on-chip sample memory under the direction of an external microcontroller. The controller programs a sample-rate divider over a small memory-mapped bus. It then raises an enable line. From that point the block stores one byte per divider tick until the memory holds its full count of samples. When the memory is full, the block raises a full flag and stops writing.

The controller reacts to the flag by dropping enable. It then drains the memory through a single data register, one byte per read strobe, oldest sample first. Once the final sample has been read, the flag clears, both pointers return to zero and the block waits for the next rising edge of enable to begin a new capture. The enable line, the bus strobes and, by default, the sampled inputs all pass through two-flop synchronizers. Each strobe acts on its synchronized rising edge.

Top module: `la_capture_ctrl`

## Requirements
- R1: Input line k of `smp_in` is stored in bit k of each sample byte, for k from 0 to 7, and comes back in bit k of `bus_rdata`.
- R2: With enable held high, the block stores exactly 4096 samples and then drives `buf_full` high.
- R3: While `buf_full` is high, no further sample is written even if enable stays high, and the stored samples remain unchanged until they are read.
- R4: Samples are taken only while the synchronized enable is high. With enable low, no sample is stored, and a capture that was started keeps its stored samples.
- R5: A bus write to byte offset 0x8 loads a 16-bit divider N, with `bus_wdata[7:0]` as its low byte and `bus_wdata[15:8]` as its high byte. While capturing, one sample is taken every N+1 clocks. The divider count restarts on each rising edge of enable.
- R6: A bus read at byte offset 0x4 returns the stored samples in capture order, one per read strobe. The byte appears on `bus_rdata` one clock after the synchronized strobe edge and is held until the next read.
- R7: A read at offset 0x4 while no unread sample is held returns 0x00 and does not move the read pointer.
- R8: Reading the 4096th sample clears `buf_full` and resets both pointers. A new capture starts only on a later rising edge of enable.
- R9: A read at any offset other than 0x4 returns 0x00 and does not advance the read pointer. A write at any offset other than 0x8 leaves the divider unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable from the controller |
| buf_full | output | 1 | High once the sample memory has been filled |
| smp_in | input | 8 | Eight digital input channels |
| bus_cs | input | 1 | Bus chip select |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 4 | Bus byte address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 8 | Bus read data |

## Verification
Some properties are checked by assertions on every cycle. The write count never passes the memory depth. The flag and the count stay frozen while the memory is full and no read arrives. A read with nothing unread leaves the read pointer still and returns zero. The final read clears the flag and both pointers on the next clock. A non-zero divider never produces two ticks in a row.

Other behaviour shows only in the bench scenarios. These cover the channel-to-bit mapping, the exact sample spacing set by a divider with both bytes non-zero, and the unbroken order of a full 4096-sample drain after enable was held past the full point. They also cover the ignoring of foreign offsets and the need for a fresh enable edge to start a second capture.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

   // Which bus register a decoded access targets
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CFG  = 2'd2
   } la_reg_sel_e;

endpackage

// File: rtl/la_sync.sv
module la_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("la_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("la_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/la_rate_div.sv
module la_rate_div #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (run) begin
         if (cnt >= div) cnt <= '0;
         else            cnt <= cnt + 1'b1;
      end
   end

   assign tick = run && !restart && (cnt == div);

   // R5
   no_double_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/la_sample_buf.sv
module la_sample_buf #(
   parameter int W     = 8,
   parameter int DEPTH = 4096
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arm_req,
   input  logic         en_lvl,
   input  logic         tick,
   input  logic [W-1:0] din,
   input  logic         rd_req,
   output logic [W-1:0] rd_data,
   output logic         full
);

   localparam int AW    = $clog2(DEPTH);
   localparam int CNT_W = AW + 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DEPTH - 1);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("la_sample_buf: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [CNT_W-1:0] wr_cnt;
   logic [CNT_W-1:0] rd_cnt;
   logic             armed;
   logic             empty;
   logic             wr_fire;
   logic             rd_fire;
   logic             last_rd;

   assign full    = (wr_cnt == FULL_CNT);
   assign empty   = (rd_cnt == wr_cnt);
   assign wr_fire = armed && en_lvl && tick && !full;
   assign rd_fire = rd_req && !empty;
   assign last_rd = rd_fire && (rd_cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_cnt  <= '0;
         rd_cnt  <= '0;
         armed   <= 1'b0;
         rd_data <= '0;
      end else begin
         if (last_rd) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
            armed  <= 1'b0;
         end else begin
            if (arm_req && wr_cnt == '0) armed <= 1'b1;
            if (wr_fire) wr_cnt <= wr_cnt + 1'b1;
            if (rd_fire) rd_cnt <= rd_cnt + 1'b1;
         end
         if (rd_req) rd_data <= rd_fire ? mem[rd_cnt[AW-1:0]] : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wr_cnt[AW-1:0]] <= din;
   end

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt <= FULL_CNT);

   // R6
   rd_behind_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_cnt <= wr_cnt);

   // R3
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_req) |=> (full && $stable(wr_cnt)));

   // R7
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty) |=> ($stable(rd_cnt) && rd_data == '0));

   // R8
   drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !empty && rd_cnt == LAST_IDX) |=> (!full && wr_cnt == '0 && rd_cnt == '0));

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
   import la_cap_pkg::*;
#(
   parameter int                CHANNELS    = 8,
   parameter int                DEPTH       = 4096,
   parameter int                DIV_W       = 16,
   parameter int                ADDR_W      = 4,
   parameter int                SYNC_STAGES = 2,
   parameter bit                SYNC_DATA   = 1'b1,
   parameter logic [ADDR_W-1:0] DATA_OFS    = 4'h4,
   parameter logic [ADDR_W-1:0] CFG_OFS     = 4'h8,
   parameter logic [DIV_W-1:0]  DIV_RESET   = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap_en,
   output logic                buf_full,
   input  logic [CHANNELS-1:0] smp_in,
   input  logic                bus_cs,
   input  logic                bus_rd,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DIV_W-1:0]    bus_wdata,
   output logic [CHANNELS-1:0] bus_rdata
);

   localparam int CTL_W = 3;

   if (DATA_OFS == CFG_OFS) begin : g_bad_map
      $error("la_capture_ctrl: data and settings offsets must differ");
   end

   // control synchronizer: {enable, read strobe, write strobe}
   logic [CTL_W-1:0] ctl_q;
   logic [CTL_W-1:0] ctl_d;

   la_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cap_en, bus_cs & bus_rd, bus_cs & bus_wr}),
      .q     (ctl_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_d <= '0;
      else        ctl_d <= ctl_q;
   end

   logic en_lvl, en_rise, rd_rise, wr_rise;
   assign en_lvl  = ctl_q[2];
   assign en_rise = ctl_q[2] & ~ctl_d[2];
   assign rd_rise = ctl_q[1] & ~ctl_d[1];
   assign wr_rise = ctl_q[0] & ~ctl_d[0];

   // sampled data path, optionally synchronized
   logic [CHANNELS-1:0] smp_s;
   if (SYNC_DATA) begin : g_data_sync
      la_sync #(.W(CHANNELS), .STAGES(SYNC_STAGES)) u_data_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (smp_in),
         .q     (smp_s)
      );
   end else begin : g_data_direct
      assign smp_s = smp_in;
   end

   // register decode
   la_reg_sel_e sel;
   always_comb begin
      if (bus_addr == DATA_OFS)     sel = SEL_DATA;
      else if (bus_addr == CFG_OFS) sel = SEL_CFG;
      else                          sel = SEL_NONE;
   end

   logic [DIV_W-1:0] div_q;
   la_reg_sel_e      rd_sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= DIV_RESET;
         rd_sel_q <= SEL_NONE;
      end else begin
         if (wr_rise && sel == SEL_CFG) div_q <= bus_wdata;
         if (rd_rise) rd_sel_q <= sel;
      end
   end

   logic tick;
   la_rate_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (en_rise),
      .run     (en_lvl),
      .div     (div_q),
      .tick    (tick)
   );

   logic [CHANNELS-1:0] buf_rdata;
   la_sample_buf #(.W(CHANNELS), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_req (en_rise),
      .en_lvl  (en_lvl),
      .tick    (tick),
      .din     (smp_s),
      .rd_req  (rd_rise && sel == SEL_DATA),
      .rd_data (buf_rdata),
      .full    (buf_full)
   );

   assign bus_rdata = (rd_sel_q == SEL_DATA) ? buf_rdata : '0;

   // R9
   foreign_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && sel != SEL_DATA) |=> (bus_rdata == '0));

   // R9
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rise && sel != SEL_CFG) |=> $stable(div_q));

endmodule

// File: tb/la_capture_ctrl_tb.sv
`timescale 1ns/1ps
module la_capture_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cap_en = 1'b0;
   logic        buf_full;
   logic [7:0]  smp_in;
   logic        bus_cs = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = 4'h0;
   logic [15:0] bus_wdata = 16'h0;
   logic [7:0]  bus_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] ctr = 8'h0;
   logic       pat_mode = 1'b0;
   logic [7:0] pat = 8'h0;

   always #2 clk = ~clk;
   always @(posedge clk) ctr <= ctr + 8'd1;
   assign smp_in = pat_mode ? pat : {ctr[6:0], 1'b1};

   la_capture_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .buf_full  (buf_full),
      .smp_in    (smp_in),
      .bus_cs    (bus_cs),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      cap_en = 1'b0;
      bus_cs = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [15:0] v);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_cs = 1'b1; bus_wr = 1'b1;
      repeat (5) @(negedge clk);
      bus_cs = 1'b0; bus_wr = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_cs = 1'b1; bus_rd = 1'b1;
      repeat (5) @(negedge clk);
      v = bus_rdata;
      bus_cs = 1'b0; bus_rd = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic enable_for(input int cycles);
      @(negedge clk); cap_en = 1'b1;
      repeat (cycles) @(negedge clk);
      cap_en = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   // reset state
   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      chk(buf_full == 1'b0, "R2 reset flag", int'(buf_full), 0);
      chk(bus_rdata == 8'h00, "R6 reset rdata", int'(bus_rdata), 0);
      bus_read(4'h4, v);
      chk(v == 8'h00, "R4 no capture without enable", int'(v), 0);
   endtask

   // channel-to-bit mapping and foreign offsets
   task automatic t_bit_order();
      logic [7:0] v;
      do_reset();
      pat_mode = 1'b1;
      pat = 8'b1100_1010;
      bus_write(4'h8, 16'h0003);
      enable_for(40);
      bus_read(4'h4, v);
      chk(v == 8'hCA, "R1 pattern CA", int'(v), 'hCA);
      bus_read(4'h0, v);
      chk(v == 8'h00, "R9 read offset 0", int'(v), 0);
      bus_read(4'h4, v);
      chk(v == 8'hCA, "R9 pointer kept after foreign read", int'(v), 'hCA);
      pat = 8'b0000_0001;
      enable_for(20);
      pat = 8'b1000_0000;
      enable_for(20);
      pat_mode = 1'b0;
   endtask

   // divider with both bytes non-zero, empty reads
   task automatic t_rate();
      logic [7:0] v, prev;
      do_reset();
      pat_mode = 1'b0;
      bus_write(4'h8, 16'h0101);
      bus_write(4'h0, 16'h0000);
      bus_write(4'h4, 16'h0000);
      enable_for(2000);
      bus_read(4'h4, prev);
      chk(prev[0] == 1'b1, "R5 first sample present", int'(prev), 1);
      for (int i = 1; i < 7; i++) begin
         bus_read(4'h4, v);
         chk(v == prev + 8'd4, "R5 spacing 258 clocks", int'(v), int'(prev + 8'd4));
         prev = v;
      end
      bus_read(4'h4, v);
      bus_read(4'h4, v);
      chk(v == 8'h00, "R7 empty read 9", int'(v), 0);
      bus_read(4'h4, v);
      chk(v == 8'h00, "R7 empty read 10", int'(v), 0);
      enable_for(600);
      bus_read(4'h4, v);
      chk(v[0] == 1'b1, "R7 pointer held, new sample readable", int'(v), 1);
      chk(buf_full == 1'b0, "R4 partial capture not full", int'(buf_full), 0);
   endtask

   // full capture, hold past full, drain, re-arm
   task automatic t_full();
      logic [7:0] v, prev;
      int cyc;
      do_reset();
      bus_write(4'h8, 16'h0000);
      @(negedge clk); cap_en = 1'b1;
      cyc = 0;
      while (!buf_full && cyc < 6000) begin
         @(negedge clk); cyc++;
      end
      chk(cyc >= 4096 && cyc <= 4110, "R2 full after 4096 samples", cyc, 4096);
      repeat (300) @(negedge clk);
      cap_en = 1'b0;
      repeat (6) @(negedge clk);
      chk(buf_full == 1'b1, "R3 full held with enable high", int'(buf_full), 1);
      bus_read(4'h4, prev);
      chk(prev[0] == 1'b1, "R6 first sample", int'(prev), 1);
      for (int i = 1; i < 4096; i++) begin
         if (i == 4095)
            chk(buf_full == 1'b1, "R8 full until last read", int'(buf_full), 1);
         bus_read(4'h4, v);
         chk(v == prev + 8'd2, "R3 contiguous order", int'(v), int'(prev + 8'd2));
         prev = v;
      end
      chk(buf_full == 1'b0, "R8 flag cleared after drain", int'(buf_full), 0);
      bus_read(4'h4, v);
      chk(v == 8'h00, "R8 pointers reset", int'(v), 0);
      enable_for(30);
      bus_read(4'h4, v);
      chk(v[0] == 1'b1, "R8 new capture on enable edge", int'(v), 1);
      chk(buf_full == 1'b0, "R8 short capture not full", int'(buf_full), 0);
   endtask

   initial begin
      t_reset();
      t_bit_order();
      t_rate();
      t_full();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule